// File: doc/BRIEF.md
# Stateful NOR Row Logic Engine

This block holds one row of single-bit storage cells and changes it only through a stream of micro-operations. A command sets one cell to a constant, or computes NOT of one cell or NOR of two cells and writes the result into a third cell of the same row. No result leaves the block on a data port. Arithmetic built on top of the engine is a sequence of such commands, and the row itself holds every intermediate value.

A gate result does not overwrite its target cell. The target keeps the AND of its old value and the gate output, so a sequence must set the target to 1 first to get a plain NOT or NOR. A separate host port loads operands and reads back results between sequences. Three counters report the cost of a sequence: accepted operations, which is the latency in cycles; gate operations; and the number of distinct cells the sequence has used, which is its footprint.

Top module: `nor_row_engine`

## Requirements
- R1: After reset every cell reads 0, all three counters read 0, `err_o` is low and `cmd_ready_o` is high.
- R2: Opcode 0 sets the single output cell to 0 and opcode 1 sets it to 1, whatever value the cell held before.
- R3: Opcode 2 (NOT) leaves the output cell at its old value ANDed with the inverse of input cell A.
- R4: Opcode 3 (NOR) leaves the output cell at its old value ANDed with NOR(A, B). A and B may be the same cell.
- R5: Each accepted legal command adds exactly 1 to `op_cnt_o`. Only opcodes 2 and 3 also add 1 to `gate_cnt_o`. While `cmd_valid_i` is low, both counters hold.
- R6: `area_cnt_o` counts the distinct cell indices that accepted legal commands have used, each index once. An init uses only its output. NOT uses A and the output. NOR uses A, B and the output. Host accesses are not counted.
- R7: A command whose used index is ROW_LEN or above, or whose used input index equals its output index, sets `err_o`. `err_o` stays set until reset. Such a command changes neither the row nor any counter.
- R8: While `host_req_i` is high, `cmd_ready_o` is low and no command is accepted. A host write (`host_we_i` high) stores `host_wdata_i` at `host_addr_i` in that cycle. A host read returns the addressed cell on `host_rdata_o` in the same cycle, and returns 0 when the address is out of range. Host accesses leave the counters unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | A command is offered |
| cmd_ready_o | output | 1 | The engine can take a command |
| cmd_op_i | input | 2 | Opcode: 0 INIT0, 1 INIT1, 2 NOT, 3 NOR |
| cmd_in_a_i | input | IDX_W | Index of input cell A |
| cmd_in_b_i | input | IDX_W | Index of input cell B (NOR only) |
| cmd_out_i | input | IDX_W | Index of the output cell |
| host_req_i | input | 1 | Host access in progress |
| host_we_i | input | 1 | The host access is a write |
| host_addr_i | input | IDX_W | Cell index for the host access |
| host_wdata_i | input | 1 | Bit to store on a host write |
| host_rdata_o | output | 1 | Addressed cell, combinational |
| err_o | output | 1 | Sticky illegal-command flag |
| op_cnt_o | output | CNT_W | Accepted operations |
| gate_cnt_o | output | CNT_W | Accepted NOT/NOR operations |
| area_cnt_o | output | CNT_W | Distinct cells used |

## Verification
The bench targets the AND-with-old-value rule. Each gate is driven into a target that held 0 and into one that held 1. A design that overwrites the target would return the raw gate value where 0 is expected. The bench also issues a NOR with both inputs on one cell and then reuses cells that are already counted. A design that counts cells per use rather than per index would give a larger footprint. Commands are offered while the host holds the port, and illegal commands are sent with an input equal to the output or with an index out of range. A design without the guards would change the row or a counter, and a design without a sticky error flag would lose the flag on the next legal command.

// File: rtl/nre_pkg.sv
package nre_pkg;
  typedef enum logic [1:0] {
    OP_INIT0 = 2'd0,
    OP_INIT1 = 2'd1,
    OP_NOT   = 2'd2,
    OP_NOR   = 2'd3
  } nre_op_e;
endpackage

// File: rtl/nre_decode.sv
module nre_decode import nre_pkg::*; #(
  parameter int ROW_LEN = 1024,
  parameter int IDX_W   = 11
) (
  input  nre_op_e          op_i,
  input  logic [IDX_W-1:0] a_i,
  input  logic [IDX_W-1:0] b_i,
  input  logic [IDX_W-1:0] out_i,
  output logic             legal_o,
  output logic             uses_a_o,
  output logic             uses_b_o,
  output logic             is_gate_o
);
  localparam logic [IDX_W:0] LIM = (IDX_W+1)'(ROW_LEN);

  logic a_ok, b_ok, o_ok;

  assign a_ok = {1'b0, a_i}   < LIM && a_i != out_i;
  assign b_ok = {1'b0, b_i}   < LIM && b_i != out_i;
  assign o_ok = {1'b0, out_i} < LIM;

  assign uses_a_o  = (op_i == OP_NOT) || (op_i == OP_NOR);
  assign uses_b_o  = (op_i == OP_NOR);
  assign is_gate_o = uses_a_o;
  assign legal_o   = o_ok && (!uses_a_o || a_ok) && (!uses_b_o || b_ok);
endmodule

// File: rtl/nre_row.sv
module nre_row import nre_pkg::*; #(
  parameter int ROW_LEN = 1024,
  parameter int IDX_W   = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             exec_i,
  input  nre_op_e          op_i,
  input  logic [IDX_W-1:0] a_i,
  input  logic [IDX_W-1:0] b_i,
  input  logic [IDX_W-1:0] out_i,
  input  logic             host_we_i,
  input  logic [IDX_W-1:0] host_addr_i,
  input  logic             host_wdata_i,
  output logic             host_rdata_o
);
  localparam int AW = $clog2(ROW_LEN);
  localparam logic [IDX_W:0] LIM = (IDX_W+1)'(ROW_LEN);

  logic [ROW_LEN-1:0] row_q;
  logic [AW-1:0] ai, bi, oi, hi;
  logic gate, next_bit, host_ok;

  assign ai = a_i[AW-1:0];
  assign bi = b_i[AW-1:0];
  assign oi = out_i[AW-1:0];
  assign hi = host_addr_i[AW-1:0];
  assign host_ok = {1'b0, host_addr_i} < LIM;

  always_comb begin
    unique case (op_i)
      OP_INIT0: next_bit = 1'b0;
      OP_INIT1: next_bit = 1'b1;
      default: begin
        gate     = (op_i == OP_NOT) ? ~row_q[ai] : ~(row_q[ai] | row_q[bi]);
        next_bit = row_q[oi] & gate;   // target keeps AND of old value
      end
    endcase
    if (op_i == OP_INIT0 || op_i == OP_INIT1) gate = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) row_q <= '0;
    else if (exec_i) row_q[oi] <= next_bit;
    else if (host_we_i && host_ok) row_q[hi] <= host_wdata_i;
  end

  assign host_rdata_o = host_ok ? row_q[hi] : 1'b0;
endmodule

// File: rtl/nre_usage.sv
module nre_usage #(
  parameter int ROW_LEN = 1024,
  parameter int IDX_W   = 11,
  parameter int CNT_W   = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             exec_i,
  input  logic             is_gate_i,
  input  logic             uses_a_i,
  input  logic             uses_b_i,
  input  logic [IDX_W-1:0] a_i,
  input  logic [IDX_W-1:0] b_i,
  input  logic [IDX_W-1:0] out_i,
  output logic [CNT_W-1:0] op_cnt_o,
  output logic [CNT_W-1:0] gate_cnt_o,
  output logic [CNT_W-1:0] area_cnt_o
);
  localparam int AW = $clog2(ROW_LEN);

  logic [ROW_LEN-1:0] seen_q;
  logic [AW-1:0] ai, bi, oi;
  logic new_o, new_a, new_b;
  logic [1:0] new_n;

  assign ai = a_i[AW-1:0];
  assign bi = b_i[AW-1:0];
  assign oi = out_i[AW-1:0];

  assign new_o = !seen_q[oi];
  assign new_a = uses_a_i && !seen_q[ai];
  assign new_b = uses_b_i && !seen_q[bi] && (bi != ai);
  assign new_n = {1'b0, new_o} + {1'b0, new_a} + {1'b0, new_b};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q     <= '0;
      op_cnt_o   <= '0;
      gate_cnt_o <= '0;
      area_cnt_o <= '0;
    end else if (exec_i) begin
      seen_q[oi] <= 1'b1;
      if (uses_a_i) seen_q[ai] <= 1'b1;
      if (uses_b_i) seen_q[bi] <= 1'b1;
      op_cnt_o   <= op_cnt_o + 1'b1;
      gate_cnt_o <= gate_cnt_o + CNT_W'(is_gate_i);
      area_cnt_o <= area_cnt_o + CNT_W'(new_n);
    end
  end
endmodule

// File: rtl/nor_row_engine.sv
module nor_row_engine import nre_pkg::*; #(
  parameter int ROW_LEN = 1024,
  parameter int IDX_W   = $clog2(ROW_LEN) + 1,
  parameter int CNT_W   = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  output logic             cmd_ready_o,
  input  logic [1:0]       cmd_op_i,
  input  logic [IDX_W-1:0] cmd_in_a_i,
  input  logic [IDX_W-1:0] cmd_in_b_i,
  input  logic [IDX_W-1:0] cmd_out_i,
  input  logic             host_req_i,
  input  logic             host_we_i,
  input  logic [IDX_W-1:0] host_addr_i,
  input  logic             host_wdata_i,
  output logic             host_rdata_o,
  output logic             err_o,
  output logic [CNT_W-1:0] op_cnt_o,
  output logic [CNT_W-1:0] gate_cnt_o,
  output logic [CNT_W-1:0] area_cnt_o
);
  nre_op_e op;
  logic fire, legal, uses_a, uses_b, is_gate, exec, err_q;

  assign op          = nre_op_e'(cmd_op_i);
  assign cmd_ready_o = !host_req_i;
  assign fire        = cmd_valid_i && cmd_ready_o;
  assign exec        = fire && legal;

  nre_decode #(.ROW_LEN(ROW_LEN), .IDX_W(IDX_W)) u_dec (
    .op_i(op), .a_i(cmd_in_a_i), .b_i(cmd_in_b_i), .out_i(cmd_out_i),
    .legal_o(legal), .uses_a_o(uses_a), .uses_b_o(uses_b), .is_gate_o(is_gate)
  );

  nre_row #(.ROW_LEN(ROW_LEN), .IDX_W(IDX_W)) u_row (
    .clk_i, .rst_ni, .exec_i(exec), .op_i(op),
    .a_i(cmd_in_a_i), .b_i(cmd_in_b_i), .out_i(cmd_out_i),
    .host_we_i(host_req_i && host_we_i), .host_addr_i, .host_wdata_i, .host_rdata_o
  );

  nre_usage #(.ROW_LEN(ROW_LEN), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_use (
    .clk_i, .rst_ni, .exec_i(exec), .is_gate_i(is_gate),
    .uses_a_i(uses_a), .uses_b_i(uses_b),
    .a_i(cmd_in_a_i), .b_i(cmd_in_b_i), .out_i(cmd_out_i),
    .op_cnt_o, .gate_cnt_o, .area_cnt_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else if (fire && !legal) err_q <= 1'b1;
  end

  assign err_o = err_q;
endmodule

// File: rtl/nre_checker.sv
module nre_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_valid_i,
  input logic             cmd_ready_o,
  input logic             host_req_i,
  input logic             err_o,
  input logic [CNT_W-1:0] op_cnt_o,
  input logic [CNT_W-1:0] gate_cnt_o,
  input logic [CNT_W-1:0] area_cnt_o
);
  assert_host_blocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_req_i |-> !cmd_ready_o);

  assert_idle_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_valid_i && cmd_ready_o) |=> ($stable(op_cnt_o) && $stable(gate_cnt_o) && $stable(area_cnt_o)));

  assert_op_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o) |=> (op_cnt_o == $past(op_cnt_o) || op_cnt_o == $past(op_cnt_o) + 1'b1));

  assert_gate_le_ops_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_cnt_o <= op_cnt_o);

  assert_area_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o) |=> (area_cnt_o - $past(area_cnt_o) <= CNT_W'(3)));

  assert_err_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  assert_err_no_count_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> ($stable(op_cnt_o) && $stable(area_cnt_o)));
endmodule

bind nor_row_engine nre_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_ready_o(cmd_ready_o),
  .host_req_i(host_req_i), .err_o(err_o), .op_cnt_o(op_cnt_o),
  .gate_cnt_o(gate_cnt_o), .area_cnt_o(area_cnt_o)
);

// File: tb/nor_row_engine_tb.sv
module nor_row_engine_tb;
  localparam int ROW_LEN = 1024;
  localparam int IDX_W   = 11;
  localparam int CNT_W   = 32;

  // {op[1:0], a, b, old_out, expected_out}
  localparam logic [5:0] VEC [8] = '{
    6'b10_0_0_1_1, 6'b10_1_0_1_0, 6'b10_0_0_0_0, 6'b11_0_0_1_1,
    6'b11_1_0_1_0, 6'b11_0_0_0_0, 6'b01_0_0_0_1, 6'b00_0_0_1_0
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cmd_valid_i = 1'b0, cmd_ready_o;
  logic [1:0] cmd_op_i = '0;
  logic [IDX_W-1:0] cmd_in_a_i = '0, cmd_in_b_i = '0, cmd_out_i = '0;
  logic host_req_i = 1'b0, host_we_i = 1'b0, host_wdata_i = 1'b0, host_rdata_o;
  logic [IDX_W-1:0] host_addr_i = '0;
  logic err_o;
  logic [CNT_W-1:0] op_cnt_o, gate_cnt_o, area_cnt_o;

  int n_chk = 0, n_fail = 0;
  int exp_ops = 0, exp_gates = 0, exp_area = 0;
  bit seen [ROW_LEN];

  always #4 clk_i = ~clk_i;

  nor_row_engine #(.ROW_LEN(ROW_LEN), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_dut (.*);

  task automatic check(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic host_wr(int addr, bit v);
    @(negedge clk_i);
    host_req_i = 1'b1; host_we_i = 1'b1; host_addr_i = IDX_W'(addr); host_wdata_i = v;
    @(negedge clk_i);
    host_req_i = 1'b0; host_we_i = 1'b0;
  endtask

  task automatic host_rd(int addr, output bit v);
    @(negedge clk_i);
    host_req_i = 1'b1; host_we_i = 1'b0; host_addr_i = IDX_W'(addr);
    #1 v = host_rdata_o;
    host_req_i = 1'b0;
  endtask

  task automatic cmd(int op, int a, int b, int o);
    @(negedge clk_i);
    cmd_valid_i = 1'b1; cmd_op_i = 2'(op);
    cmd_in_a_i = IDX_W'(a); cmd_in_b_i = IDX_W'(b); cmd_out_i = IDX_W'(o);
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
  endtask

  task automatic touch(int i);
    if (!seen[i]) begin seen[i] = 1'b1; exp_area++; end
  endtask

  task automatic model(int op, int a, int b, int o);
    exp_ops++;
    if (op >= 2) exp_gates++;
    touch(o);
    if (op >= 2) touch(a);
    if (op == 3) touch(b);
  endtask

  task automatic check_counts(string req);
    check(req, "op_cnt", op_cnt_o, exp_ops);
    check(req, "gate_cnt", gate_cnt_o, exp_gates);
    check(req, "area_cnt", area_cnt_o, exp_area);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit v;
    repeat (3) @(negedge clk_i);
    // R1: reset state
    check("R1", "ready", cmd_ready_o, 1);
    check("R1", "err", err_o, 0);
    check_counts("R1");
    rst_ni = 1'b1;
    host_rd(5, v);
    check("R1", "cell 5", v, 0);

    // table walk: R2 inits, R3 NOT, R4 NOR
    for (int i = 0; i < 8; i++) begin
      int op, a, b, o;
      op = int'(VEC[i][5:4]); a = 16 + 4*i; b = 17 + 4*i; o = 18 + 4*i;
      host_wr(a, VEC[i][3]);
      host_wr(b, VEC[i][2]);
      host_wr(o, VEC[i][1]);
      cmd(op, a, b, o);
      model(op, a, b, o);
      host_rd(o, v);
      check(op < 2 ? "R2" : (op == 2 ? "R3" : "R4"), $sformatf("vector %0d", i), v, VEC[i][0]);
    end
    check_counts("R5");

    // R5: idle cycles keep counters
    repeat (3) @(negedge clk_i);
    check_counts("R5");

    // R6: NOR with a == b, then reuse of counted cells
    host_wr(400, 1'b0);
    host_wr(401, 1'b1);
    cmd(3, 400, 400, 401);
    model(3, 400, 400, 401);
    host_rd(401, v);
    check("R4", "nor same input", v, 1);
    check("R6", "area after dup nor", area_cnt_o, exp_area);
    cmd(2, 400, 0, 401);
    model(2, 400, 0, 401);
    check_counts("R6");

    // R8: command blocked while host holds the port
    @(negedge clk_i);
    host_req_i = 1'b1; host_we_i = 1'b0; host_addr_i = IDX_W'(401);
    cmd_valid_i = 1'b1; cmd_op_i = 2'd0; cmd_out_i = IDX_W'(401);
    #1 check("R8", "ready during host", cmd_ready_o, 0);
    @(negedge clk_i);
    cmd_valid_i = 1'b0; host_req_i = 1'b0;
    host_rd(401, v);
    check("R8", "cell kept", v, 1);
    check_counts("R8");
    host_rd(1500, v);
    check("R8", "out of range read", v, 0);

    // R7: input equals output
    check("R7", "err before", err_o, 0);
    host_wr(200, 1'b1);
    cmd(2, 200, 0, 200);
    check("R7", "err set", err_o, 1);
    host_rd(200, v);
    check("R7", "cell 200 kept", v, 1);
    check_counts("R7");
    host_wr(201, 1'b1);
    cmd(0, 0, 0, 201);
    model(0, 0, 0, 201);
    host_rd(201, v);
    check("R2", "init0 after error", v, 0);
    check("R7", "err sticky", err_o, 1);
    // R7: out of range input and output
    host_wr(300, 1'b1);
    cmd(3, 2000, 5, 300);
    host_rd(300, v);
    check("R7", "cell 300 kept", v, 1);
    cmd(1, 0, 0, 1030);
    check_counts("R7");
    check("R7", "err still set", err_o, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule